// File: doc/BRIEF.md
# Bus Target Backend Read Controller

This controller sits between an abstracted bus-target front end and a simple backend data port. A transaction request from the front end causes a one-cycle data-phase start pulse. Alongside it the controller presents a 3-bit base-region select and a read or write qualifier, and it holds these until the transaction ends. For reads, it raises a read-ready strobe and moves one word in every cycle where the backend also raises its data-available strobe. It captures the word either on that same edge or on the edge after, depending on a sync-mode input. The backend word address steps by 4 for each word moved.

Two latency watchdogs protect the bus side. If the backend does not deliver the first word within the initial limit, the controller ends the transaction with a retry indication. If the backend stalls between later words for too long, the controller ends it with a disconnect-without-data indication. The initial limit depends on the sync mode and on a build-time option that models one extra internal pipeline cycle. The controller may fetch a fixed number of words beyond what was requested. The data-write path, bus pins, parity and configuration space are outside this block.

Top module: `tgt_rd_ctrl`

## Requirements
- R1: `ph_start` is high for exactly one cycle, two cycles after the cycle in which `req_start` is sampled high in idle. `req_start` is ignored while a transaction is in progress.
- R2: `bar_sel`, and `rd_cyc` (for `req_write`=0) or `wr_cyc` (for `req_write`=1), become valid in the same cycle as `ph_start`. They stay valid through the `done` cycle and are cleared in the cycle after `done`. They are 0 outside a transaction.
- R3: For a read, `rdy_stb` rises in the cycle after `ph_start`. For a write, `done` is raised in the cycle after `ph_start` and `rdy_stb` never rises.
- R4: A word moves only in a cycle where `rdy_stb` and `be_avail` are both high. With `sync_mode`=0 the word is captured from `be_data` at the end of that cycle. With `sync_mode`=1 it is captured at the end of the next cycle. `rd_vld` is high for one cycle after each capture, with the word on `rd_data`.
- R5: The initial limit is INIT_LIM − FAM_EXTRA − `sync_mode` cycles, counted from the first `rdy_stb` cycle. If no word has moved after that many `rdy_stb` cycles, `done` and `retry` rise together in the next cycle.
- R6: After a word moves, the next word must move within the following BURST_LIM cycles. Otherwise `done` and `disc` rise together in the cycle after the last of those cycles.
- R7: A read moves `req_words`+1+PREFETCH words; `req_words` counts requested words minus one. `done` rises in the cycle after the last word moves, with `retry` and `disc` low.
- R8: `be_addr` equals `req_offset` when the first word moves, and it increases by 4 after each word moves.
- R9: `done` lasts one cycle. `rdy_stb` is low in the `done` cycle, and a new `req_start` is accepted from the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Transaction request from the front end |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bar | input | 3 | Base-region select of the request |
| req_offset | input | AW | Starting byte address in the backend |
| req_words | input | LW | Requested word count minus one |
| sync_mode | input | 1 | 0 = capture on the strobe edge, 1 = capture one edge later |
| ph_start | output | 1 | Data-phase start pulse |
| bar_sel | output | 3 | Base-region select, held during the transaction |
| rd_cyc | output | 1 | Read qualifier |
| wr_cyc | output | 1 | Write qualifier |
| rdy_stb | output | 1 | Controller ready to take a word |
| be_avail | input | 1 | Backend has a word available |
| be_addr | output | AW | Backend byte address |
| be_data | input | DW | Backend word |
| rd_data | output | DW | Captured word |
| rd_vld | output | 1 | `rd_data` holds a new word |
| done | output | 1 | End of transaction |
| retry | output | 1 | Ended by initial-latency timeout |
| disc | output | 1 | Ended by burst-latency timeout |

## Verification
The bench builds the block with FAM_EXTRA=1 and PREFETCH=1, so the initial limits are 10 and 9 cycles and every read moves one word beyond the request. With those values, the last in-time and first out-of-time first words are placed in both sync modes, and an eighth-cycle burst word is set against a ninth-cycle stall. The prefetched word is checked through the count and the data stream.

// File: rtl/tgt_rd_ctrl.sv
module tgt_rd_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int LW        = 4,
  parameter int PREFETCH  = 0,
  parameter int FAM_EXTRA = 0,
  parameter int INIT_LIM  = 11,
  parameter int BURST_LIM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic          req_write,
  input  logic [2:0]    req_bar,
  input  logic [AW-1:0] req_offset,
  input  logic [LW-1:0] req_words,
  input  logic          sync_mode,
  output logic          ph_start,
  output logic [2:0]    bar_sel,
  output logic          rd_cyc,
  output logic          wr_cyc,
  output logic          rdy_stb,
  input  logic          be_avail,
  output logic [AW-1:0] be_addr,
  input  logic [DW-1:0] be_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  output logic          done,
  output logic          retry,
  output logic          disc
);
  localparam int TW = LW + 1 + $clog2(PREFETCH + 2);
  localparam int CW = $clog2(INIT_LIM + BURST_LIM + 1);

  typedef enum logic [2:0] {IDLE, DLY, STRT, XFER, FIN} st_t;
  st_t st;

  logic          qual_on, wr_q, sync_q, first, cap_pend;
  logic [2:0]    bar_q;
  logic [TW-1:0] total, moved;
  logic [CW-1:0] wcnt, lim;
  logic          xfer;

  assign xfer    = rdy_stb && be_avail;
  assign lim     = first ? CW'(INIT_LIM - FAM_EXTRA) - CW'(sync_q) : CW'(BURST_LIM);
  assign bar_sel = qual_on ? bar_q : 3'd0;
  assign rd_cyc  = qual_on && !wr_q;
  assign wr_cyc  = qual_on && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; qual_on <= 1'b0; wr_q <= 1'b0; sync_q <= 1'b0; bar_q <= 3'd0;
      first <= 1'b0; cap_pend <= 1'b0; total <= '0; moved <= '0; wcnt <= '0;
      ph_start <= 1'b0; rdy_stb <= 1'b0; be_addr <= '0; rd_data <= '0;
      rd_vld <= 1'b0; done <= 1'b0; retry <= 1'b0; disc <= 1'b0;
    end else begin
      ph_start <= 1'b0;
      done     <= 1'b0;
      retry    <= 1'b0;
      disc     <= 1'b0;
      rd_vld   <= 1'b0;
      cap_pend <= 1'b0;
      if (cap_pend) begin
        rd_data <= be_data;
        rd_vld  <= 1'b1;
      end
      case (st)
        IDLE: if (req_start) begin
          st      <= DLY;
          wr_q    <= req_write;
          bar_q   <= req_bar;
          sync_q  <= sync_mode;
          be_addr <= req_offset;
          total   <= TW'(req_words) + TW'(1 + PREFETCH);
          moved   <= '0;
        end
        DLY: begin
          st       <= STRT;
          ph_start <= 1'b1;
          qual_on  <= 1'b1;
        end
        STRT: begin
          if (wr_q) begin
            st   <= FIN;
            done <= 1'b1;
          end else begin
            st      <= XFER;
            rdy_stb <= 1'b1;
            wcnt    <= '0;
            first   <= 1'b1;
          end
        end
        XFER: begin
          if (xfer) begin
            be_addr <= be_addr + AW'(4);
            moved   <= moved + TW'(1);
            wcnt    <= '0;
            first   <= 1'b0;
            if (sync_q) cap_pend <= 1'b1;
            else begin
              rd_data <= be_data;
              rd_vld  <= 1'b1;
            end
            if (moved == total - TW'(1)) begin
              st      <= FIN;
              rdy_stb <= 1'b0;
              done    <= 1'b1;
            end
          end else if (wcnt == lim - CW'(1)) begin
            st      <= FIN;
            rdy_stb <= 1'b0;
            done    <= 1'b1;
            retry   <= first;
            disc    <= !first;
          end else begin
            wcnt <= wcnt + CW'(1);
          end
        end
        FIN: begin
          st      <= IDLE;
          qual_on <= 1'b0;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module tgt_rd_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph_start,
  input logic          rd_cyc,
  input logic          wr_cyc,
  input logic          rdy_stb,
  input logic          be_avail,
  input logic [AW-1:0] be_addr,
  input logic          done,
  input logic          retry,
  input logic          disc
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_start |=> !ph_start);  // R1
  AST_QUAL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ph_start |-> (rd_cyc ^ wr_cyc));  // R2
  AST_QUAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && !done) |=> rd_cyc);  // R2
  AST_QUAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !(rd_cyc || wr_cyc));  // R2
  AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_start && rd_cyc) |=> rdy_stb);  // R3
  AST_NO_READY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |-> !rdy_stb);  // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_stb && be_avail) |=> be_addr == $past(be_addr) + AW'(4));  // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_stb && !be_avail) |=> $stable(be_addr));  // R8
  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (retry || disc) |-> (done && !(retry && disc)));  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rdy_stb ##1 !done));  // R9
endmodule

bind tgt_rd_ctrl tgt_rd_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph_start(ph_start), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc),
  .rdy_stb(rdy_stb), .be_avail(be_avail), .be_addr(be_addr), .done(done),
  .retry(retry), .disc(disc)
);

// File: tb/tgt_rd_ctrl_bench.sv
`timescale 1ns/1ps
module tgt_rd_ctrl_bench;
  localparam int AW = 16, DW = 32, LW = 4, PF = 1, FAM = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 1'b0, req_write = 1'b0, sync_mode = 1'b0, be_avail = 1'b0;
  logic [2:0] req_bar = '0;
  logic [AW-1:0] req_offset = '0;
  logic [LW-1:0] req_words = '0;
  logic ph_start, rd_cyc, wr_cyc, rdy_stb, rd_vld, done, retry, disc;
  logic [2:0] bar_sel;
  logic [AW-1:0] be_addr;
  logic [DW-1:0] be_data, rd_data;

  always #2.5 clk = ~clk;

  tgt_rd_ctrl #(.AW(AW), .DW(DW), .LW(LW), .PREFETCH(PF), .FAM_EXTRA(FAM)) u_tgt_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write), .req_bar(req_bar),
    .req_offset(req_offset), .req_words(req_words), .sync_mode(sync_mode), .ph_start(ph_start),
    .bar_sel(bar_sel), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .rdy_stb(rdy_stb), .be_avail(be_avail),
    .be_addr(be_addr), .be_data(be_data), .rd_data(rd_data), .rd_vld(rd_vld), .done(done),
    .retry(retry), .disc(disc));

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a + 16'h1357};
  endfunction
  assign be_data = pat(sync_mode ? be_addr - 16'd4 : be_addr);

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {kind, sync, write, bar, offset, words-1, first delay, gap}; kind 0 ok, 1 retry, 2 disc, 3 write
  localparam logic [34:0] VEC [9] = '{
    {2'd0, 1'b0, 1'b0, 3'd1, 16'h0100, 4'd1, 4'd0,  4'd0},
    {2'd0, 1'b1, 1'b0, 3'd2, 16'h0200, 4'd0, 4'd3,  4'd2},
    {2'd0, 1'b0, 1'b0, 3'd3, 16'h0300, 4'd0, 4'd9,  4'd0},
    {2'd1, 1'b0, 1'b0, 3'd4, 16'h0400, 4'd2, 4'd10, 4'd0},
    {2'd0, 1'b1, 1'b0, 3'd0, 16'h0500, 4'd1, 4'd8,  4'd1},
    {2'd1, 1'b1, 1'b0, 3'd6, 16'h0600, 4'd0, 4'd9,  4'd0},
    {2'd0, 1'b0, 1'b0, 3'd7, 16'h0700, 4'd1, 4'd1,  4'd7},
    {2'd2, 1'b1, 1'b0, 3'd1, 16'h0800, 4'd2, 4'd0,  4'd8},
    {2'd3, 1'b0, 1'b1, 3'd5, 16'h0900, 4'd0, 4'd0,  4'd0}
  };

  task automatic run(logic [1:0] kind, logic sy, logic wr, logic [2:0] bar, logic [15:0] off,
                     logic [3:0] w, int d0, int gap, bit poke);
    int cyc, moved, got, idle, last_x, done_c, starts, lim, want;
    bit r_seen, d_seen;
    moved = 0; got = 0; idle = 0; last_x = -1; done_c = -1; starts = 0;
    r_seen = 0; d_seen = 0;
    lim = 11 - FAM - int'(sy);
    @(negedge clk);
    req_start = 1'b1; req_write = wr; req_bar = bar; req_offset = off; req_words = w; sync_mode = sy;
    @(negedge clk);
    req_start = 1'b0;
    chk(ph_start == 1'b0, "R1 no early start", 32'(ph_start), 0);
    @(negedge clk);
    chk(ph_start == 1'b1, "R1 start two cycles later", 32'(ph_start), 1);
    chk(bar_sel == bar, "R2 bar with start", 32'(bar_sel), 32'(bar));
    chk(rd_cyc == !wr && wr_cyc == wr, "R2 qualifier with start", {rd_cyc, wr_cyc}, {!wr, wr});
    chk(rdy_stb == 1'b0, "R3 no ready in start cycle", 32'(rdy_stb), 0);
    cyc = 2;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cyc++;
      req_start = poke && (cyc == 4);
      starts += int'(ph_start);
      if (cyc == 3) chk(rdy_stb == !wr, "R3 ready after start", 32'(rdy_stb), 32'(!wr));
      if (rdy_stb) begin
        want = (moved == 0) ? d0 : gap;
        if (idle == want) begin
          be_avail = 1'b1;
          chk(be_addr == off + 16'(4 * moved), "R8 address at transfer", 32'(be_addr), 32'(off + 16'(4 * moved)));
          moved++; idle = 0; last_x = cyc;
        end else begin
          be_avail = 1'b0; idle++;
        end
      end else be_avail = 1'b0;
      if (rd_vld) begin
        chk(rd_data == pat(off + 16'(4 * got)), "R4 captured word", rd_data, pat(off + 16'(4 * got)));
        got++;
      end
      if (done) begin
        done_c = cyc; r_seen = retry; d_seen = disc;
        chk(rdy_stb == 1'b0, "R9 ready low in done cycle", 32'(rdy_stb), 0);
        chk(rd_cyc == !wr && wr_cyc == wr, "R2 qualifier held in done cycle", {rd_cyc, wr_cyc}, {!wr, wr});
        break;
      end
    end
    be_avail = 1'b0;
    req_start = 1'b0;
    if (done_c < 0) chk(0, "R9 done never seen", 0, 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      starts += int'(ph_start);
      if (rd_vld) begin
        chk(rd_data == pat(off + 16'(4 * got)), "R4 captured word late", rd_data, pat(off + 16'(4 * got)));
        got++;
      end
      if (k == 0) begin
        chk(!rd_cyc && !wr_cyc && bar_sel == 3'd0, "R2 qualifiers cleared", {rd_cyc, wr_cyc, bar_sel}, 0);
        chk(!done && !rdy_stb, "R9 done one cycle", {done, rdy_stb}, 0);
      end
    end
    if (poke) chk(starts == 0, "R1 busy request ignored", 32'(starts), 0);
    case (kind)
      2'd0: begin
        chk(moved == int'(w) + 1 + PF, "R7 word count with prefetch", 32'(moved), 32'(int'(w) + 1 + PF));
        chk(got == moved, "R4 words delivered", 32'(got), 32'(moved));
        chk(done_c == last_x + 1, "R7 done after last word", 32'(done_c), 32'(last_x + 1));
        chk(!r_seen && !d_seen, "R7 normal end", {r_seen, d_seen}, 0);
      end
      2'd1: begin
        chk(moved == 0 && got == 0, "R5 nothing moved on retry", 32'(moved), 0);
        chk(done_c == 3 + lim, "R5 retry timing", 32'(done_c), 32'(3 + lim));
        chk(r_seen && !d_seen, "R5 retry flag", {r_seen, d_seen}, 2);
      end
      2'd2: begin
        chk(moved == 1 && got == 1, "R6 one word before stall", 32'(moved), 1);
        chk(done_c == last_x + 9, "R6 disconnect timing", 32'(done_c), 32'(last_x + 9));
        chk(!r_seen && d_seen, "R6 disconnect flag", {r_seen, d_seen}, 1);
      end
      default: begin
        chk(done_c == 3 && moved == 0, "R3 write ends after start", 32'(done_c), 3);
        chk(!r_seen && !d_seen, "R3 write end flags", {r_seen, d_seen}, 0);
      end
    endcase
  endtask

  initial begin
    logic [15:0] a0;
    repeat (3) @(negedge clk);
    chk(!ph_start && !rdy_stb && !done && !rd_vld && !rd_cyc && !wr_cyc, "R9 reset state",
        {ph_start, rdy_stb, done, rd_vld, rd_cyc, wr_cyc}, 0);
    chk(be_addr == '0 && bar_sel == 3'd0, "R2 reset qualifiers", {be_addr, 13'd0, bar_sel}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 9; i++)
      run(VEC[i][34:33], VEC[i][32], VEC[i][31], VEC[i][30:28], VEC[i][27:12],
          VEC[i][11:8], int'(VEC[i][7:4]), int'(VEC[i][3:0]), 1'b0);
    run(2'd0, 1'b0, 1'b0, 3'd2, 16'h0A00, 4'd0, 2, 3, 1'b1);
    a0 = be_addr;
    @(negedge clk);
    be_avail = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!rd_vld && be_addr == a0, "R4 backend strobe alone ignored", {rd_vld, be_addr}, {1'b0, a0});
    end
    be_avail = 1'b0;
    run(2'd0, 1'b1, 1'b0, 3'd3, 16'hFFF8, 4'd1, 0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule